// File: doc/BRIEF.md
# MDIO Clause 22 Management Master

This block lets software reach the registers of an external Ethernet PHY over the two-wire management bus. Software writes a single 32-bit command word that carries the operation, the 5-bit PHY address, the 5-bit register number and, for writes, 16 data bits. The block serializes the whole management frame onto the data line, clocked by a management clock that it derives from the system clock through a fixed divider. For a read it turns the data line around and captures the 16 bits that the PHY returns.

Progress is polled through a busy bit in the same command word. A read leaves its result and a valid flag there too. Completion of any transfer also sets a done flag in a shared cause register. That flag is gated by a mask register onto a level interrupt output. Software acknowledges it by writing zero to the flag.

The data line is split into an output, an output enable and an input, for an I/O pad. The management clock runs continuously. Frame bits change on its falling edge and are sampled on its rising edge.

Top module: `mdio_master`

## Requirements
- R1: After a synchronous reset, the command, cause and mask registers read as zero, and `irq`, `mdc` and `mdio_oe` are low.
- R2: A write to offset 0x00 starts a transfer and latches the command fields. The fields are data in bits 15:0, PHY address in bits 20:16, register number in bits 25:21, and operation in bit 26 (1 = read, 0 = write). Bit 28 reads 1 from the cycle after the command write until the frame has finished, and the latched fields read back unchanged.
- R3: A write frame is sent MSB first as follows: 32 ones, `01`, `01`, the PHY address, the register number, `10`, and then the 16 data bits. The master drives the line for all 64 bits.
- R4: A read frame carries opcode `10`. The master drives the line only for the first 46 bits and releases it from the first turnaround bit to the end of the frame.
- R5: After a read in which the PHY pulls the second turnaround bit low, bit 27 reads 1 and bits 15:0 hold the 16 bits the PHY sent, MSB first.
- R6: If the line is high during the second turnaround bit of a read, bit 27 reads 0 after completion.
- R7: A command write that arrives while bit 28 is set has no effect. The frame on the wire and the latched fields stay those of the running transfer.
- R8: Bit 4 (value 0x10) of the cause register at offset 0x7C is set when any transfer completes. A register write with bit 4 = 0 clears it, and a write with bit 4 = 1 leaves it unchanged.
- R9: Bit 4 of the mask register at offset 0x80 gates the done flag. `irq` equals cause bit 4 AND mask bit 4, one clock later.
- R10: If the transfer completes in the same cycle in which software writes 0 to cause bit 4, the flag ends up set.
- R11: `mdio_o` and `mdio_oe` change only in the clock cycle in which `mdc` falls. Input bits are sampled in the cycle in which `mdc` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Byte offset of the register access |
| reg_wen | input | 1 | Register write strobe |
| reg_ren | input | 1 | Register read strobe, data valid the next cycle |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt, done flag AND mask |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | Data line input from the pad |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |

## Verification
Two things can happen in one clock edge: the engine reports that a frame is complete, and software writes zero to the done flag of the cause register. The bench counts management clock edges on the wire up to the 64th rising edge of a frame. It then places the clearing write exactly on the clock edge where the registered completion pulse is consumed, and reads the cause register back expecting 0x10. A separate clear with no transfer in progress must read back 0, which shows that the write itself does clear the flag.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  // Register offsets (bytes)
  localparam int CMD_OFF   = 'h00;
  localparam int CAUSE_OFF = 'h7C;
  localparam int MASK_OFF  = 'h80;

  // Command word field positions
  localparam int F_DATA_LSB = 0;
  localparam int F_PHY_LSB  = 16;
  localparam int F_REG_LSB  = 21;
  localparam int F_OP_BIT   = 26;
  localparam int F_RVAL_BIT = 27;
  localparam int F_BUSY_BIT = 28;

  // Done flag position in cause and mask registers
  localparam int DONE_BIT = 4;

  // Clause 22 field widths
  localparam int PHY_W  = 5;
  localparam int REGN_W = 5;
  localparam int DAT_W  = 16;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_WAIT_FALL,
    ENG_WAIT_RISE
  } eng_state_t;

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  output logic mdc,
  output logic rise_stb,
  output logic fall_stb
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          term;

  assign term = (cnt_q == CW'(HALF_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (term) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign mdc      = mdc_q;
  assign rise_stb = term & ~mdc_q;
  assign fall_stb = term &  mdc_q;

endmodule

// File: rtl/mdio_engine.sv
module mdio_engine
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rise_stb,
  input  logic              fall_stb,
  input  logic              start,
  input  logic              is_read,
  input  logic [PHY_W-1:0]  phy,
  input  logic [REGN_W-1:0] regn,
  input  logic [DAT_W-1:0]  wdata,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              busy,
  output logic              done,
  output logic              ta_ok,
  output logic [DAT_W-1:0]  cap
);
  localparam int FRAME = PRE_LEN + 4 + PHY_W + REGN_W + 2 + DAT_W;
  localparam int TA1   = PRE_LEN + 4 + PHY_W + REGN_W;
  localparam int TA2   = TA1 + 1;
  localparam int DAT0  = TA1 + 2;
  localparam int CW    = $clog2(FRAME + 1);

  eng_state_t       st_q;
  logic [FRAME-1:0] sh_q;
  logic [FRAME-1:0] frame_w;
  logic [CW-1:0]    bcnt_q;
  logic             rd_q;

  assign frame_w = {{PRE_LEN{1'b1}}, 2'b01,
                    (is_read ? 2'b10 : 2'b01), phy, regn,
                    (is_read ? 2'b11 : 2'b10),
                    (is_read ? {DAT_W{1'b1}} : wdata)};

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ENG_IDLE;
      sh_q    <= '0;
      bcnt_q  <= '0;
      rd_q    <= 1'b0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      done    <= 1'b0;
      ta_ok   <= 1'b0;
      cap     <= '0;
    end else begin
      done <= 1'b0;
      case (st_q)
        ENG_IDLE: begin
          if (start) begin
            sh_q   <= frame_w;
            bcnt_q <= '0;
            rd_q   <= is_read;
            ta_ok  <= 1'b0;
            st_q   <= ENG_WAIT_FALL;
          end
        end
        ENG_WAIT_FALL: begin
          if (fall_stb) begin
            if (bcnt_q == CW'(FRAME)) begin
              mdio_oe <= 1'b0;
              mdio_o  <= 1'b1;
              done    <= 1'b1;
              st_q    <= ENG_IDLE;
            end else begin
              mdio_o  <= sh_q[FRAME-1];
              sh_q    <= {sh_q[FRAME-2:0], 1'b0};
              mdio_oe <= !(rd_q && (bcnt_q >= CW'(TA1)));
              st_q    <= ENG_WAIT_RISE;
            end
          end
        end
        ENG_WAIT_RISE: begin
          if (rise_stb) begin
            if (rd_q && (bcnt_q == CW'(TA2)))
              ta_ok <= !mdio_i;
            if (rd_q && (bcnt_q >= CW'(DAT0)))
              cap <= {cap[DAT_W-2:0], mdio_i};
            bcnt_q <= bcnt_q + 1'b1;
            st_q   <= ENG_WAIT_FALL;
          end
        end
        default: st_q <= ENG_IDLE;
      endcase
    end
  end

  assign busy = (st_q != ENG_IDLE);

  AST_DRIVE_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !fall_stb |=> ($stable(mdio_o) && $stable(mdio_oe))); // R11

  AST_RELEASE_ON_READ: assert property (@(posedge clk) disable iff (rst)
    (st_q == ENG_WAIT_RISE && rd_q && bcnt_q >= CW'(TA1)) |-> !mdio_oe); // R4

endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int HALF_DIV = 2,
  parameter int PRE_LEN  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wen,
  input  logic              reg_ren,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  output logic              mdc,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe
);
  logic rise_stb, fall_stb;
  logic eng_busy, eng_done, eng_ta_ok;
  logic [DAT_W-1:0] eng_cap;

  logic [PHY_W-1:0]  phy_q;
  logic [REGN_W-1:0] regn_q;
  logic [DAT_W-1:0]  data_q;
  logic              op_q, rvalid_q, cause_q, mask_q;

  logic sel_cmd, sel_cause, sel_mask, cmd_wr, start;
  logic unused_wbits;

  assign sel_cmd   = (reg_addr == ADDR_W'(CMD_OFF));
  assign sel_cause = (reg_addr == ADDR_W'(CAUSE_OFF));
  assign sel_mask  = (reg_addr == ADDR_W'(MASK_OFF));
  assign cmd_wr    = reg_wen && sel_cmd;
  assign start     = cmd_wr && !eng_busy;
  assign unused_wbits = ^reg_wdata[31:27];

  mdio_clkgen #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk(clk), .rst(rst), .mdc(mdc),
    .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  mdio_engine #(.PRE_LEN(PRE_LEN)) u_eng (
    .clk(clk), .rst(rst),
    .rise_stb(rise_stb), .fall_stb(fall_stb),
    .start(start),
    .is_read(reg_wdata[F_OP_BIT]),
    .phy(reg_wdata[F_PHY_LSB +: PHY_W]),
    .regn(reg_wdata[F_REG_LSB +: REGN_W]),
    .wdata(reg_wdata[F_DATA_LSB +: DAT_W]),
    .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .busy(eng_busy), .done(eng_done),
    .ta_ok(eng_ta_ok), .cap(eng_cap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phy_q     <= '0;
      regn_q    <= '0;
      data_q    <= '0;
      op_q      <= 1'b0;
      rvalid_q  <= 1'b0;
      cause_q   <= 1'b0;
      mask_q    <= 1'b0;
      irq       <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (start) begin
        phy_q    <= reg_wdata[F_PHY_LSB +: PHY_W];
        regn_q   <= reg_wdata[F_REG_LSB +: REGN_W];
        data_q   <= reg_wdata[F_DATA_LSB +: DAT_W];
        op_q     <= reg_wdata[F_OP_BIT];
        rvalid_q <= 1'b0;
      end else if (eng_done && op_q) begin
        data_q   <= eng_cap;
        rvalid_q <= eng_ta_ok;
      end

      // completion wins over a software clear in the same cycle
      if (eng_done)
        cause_q <= 1'b1;
      else if (reg_wen && sel_cause)
        cause_q <= cause_q & reg_wdata[DONE_BIT];

      if (reg_wen && sel_mask)
        mask_q <= reg_wdata[DONE_BIT];

      irq <= cause_q & mask_q;

      if (reg_ren) begin
        if (sel_cmd)
          reg_rdata <= {3'b000, eng_busy, rvalid_q, op_q, regn_q, phy_q, data_q};
        else if (sel_cause)
          reg_rdata <= 32'(cause_q) << DONE_BIT;
        else if (sel_mask)
          reg_rdata <= 32'(mask_q) << DONE_BIT;
        else
          reg_rdata <= '0;
      end
    end
  end

  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && eng_busy) |=> ($stable(phy_q) && $stable(regn_q) && $stable(op_q))); // R7

  AST_DONE_SETS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    eng_done |=> cause_q); // R8

  AST_VALID_NEEDS_READ: assert property (@(posedge clk) disable iff (rst)
    $rose(rvalid_q) |-> $past(op_q)); // R5

  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(mask_q)); // R9

endmodule

// File: tb/mdio_master_test.sv
module mdio_master_test;
  localparam int FR = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  reg_addr = '0;
  logic        reg_wen = 1'b0;
  logic        reg_ren = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, mdc, mdio_o, mdio_oe, mdio_i;

  logic        phy_en = 1'b0;
  logic        phy_val = 1'b1;
  logic        phy_rd = 1'b0;
  logic        phy_respond = 1'b0;
  logic [15:0] phy_data = '0;

  logic          mon_on = 1'b0;
  int            mon_cnt = 0;
  logic [FR-1:0] mon_bits = '0;
  logic [FR-1:0] mon_oe = '0;

  int checks = 0;
  int errors = 0;
  int r11_viol = 0;
  logic prev_mdc = 1'b0, prev_o = 1'b1, prev_oe = 1'b0;

  always #10 clk = ~clk;

  assign mdio_i = mdio_oe ? mdio_o : (phy_en ? phy_val : 1'b1);

  mdio_master uut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wen(reg_wen),
    .reg_ren(reg_ren), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .mdc(mdc), .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  // wire monitor: one bit per rising mdc edge
  always @(posedge mdc) begin
    #1;
    if (mon_on && mon_cnt < FR && (mon_cnt > 0 || mdio_oe)) begin
      mon_bits = {mon_bits[FR-2:0], mdio_i};
      mon_oe   = {mon_oe[FR-2:0], mdio_oe};
      mon_cnt  = mon_cnt + 1;
    end
  end

  // PHY model: drives read turnaround and data after the falling edge
  always @(negedge mdc) begin
    #1;
    if (mon_on && phy_rd && phy_respond && mon_cnt == 47) begin
      phy_en = 1'b1; phy_val = 1'b0;
    end else if (mon_on && phy_rd && phy_respond && mon_cnt >= 48 && mon_cnt < 64) begin
      phy_en = 1'b1; phy_val = phy_data[63 - mon_cnt];
    end else begin
      phy_en = 1'b0; phy_val = 1'b1;
    end
  end

  // R11: output must not move while mdc stays high
  always @(posedge clk) begin
    #2;
    if (!rst && prev_mdc && mdc && (mdio_o != prev_o || mdio_oe != prev_oe))
      r11_viol++;
    prev_mdc = mdc; prev_o = mdio_o; prev_oe = mdio_oe;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
    @(posedge clk); #1;
    reg_wen = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    reg_addr = a; reg_ren = 1'b1;
    @(posedge clk); #1;
    reg_ren = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      rd(8'h00, v);
      if (!v[28]) break;
    end
  endtask

  function automatic logic [31:0] cmd(input logic r, input logic [4:0] p,
                                      input logic [4:0] g, input logic [15:0] d);
    return {5'b0, r, g, p, d};
  endfunction

  task automatic start_mon(input logic r, input logic resp, input logic [15:0] pd);
    mon_cnt = 0; mon_bits = '0; mon_oe = '0;
    phy_rd = r; phy_respond = resp; phy_data = pd; mon_on = 1'b1;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 mdc", {63'b0, mdc}, 64'd0);
    chk("R1 oe", {63'b0, mdio_oe}, 64'd0);
    chk("R1 irq", {63'b0, irq}, 64'd0);
    @(posedge clk); #1; rst = 1'b0;
    rd(8'h00, v); chk("R1 cmd", {32'b0, v}, 64'd0);
    rd(8'h7C, v); chk("R1 cause", {32'b0, v}, 64'd0);
    rd(8'h80, v); chk("R1 mask", {32'b0, v}, 64'd0);
  endtask

  task automatic t_write();
    logic [31:0] v;
    start_mon(1'b0, 1'b0, 16'h0);
    wr(8'h00, cmd(1'b0, 5'h0B, 5'h13, 16'hA5C3));
    rd(8'h00, v);
    chk("R2 busy set", {63'b0, v[28]}, 64'd1);
    wait_idle();
    chk("R3 write frame", mon_bits,
        {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h0B, 5'h13, 2'b10, 16'hA5C3});
    chk("R3 driven all bits", mon_oe, {FR{1'b1}});
    rd(8'h00, v);
    chk("R2 fields and busy clear", {32'b0, v}, {32'b0, cmd(1'b0, 5'h0B, 5'h13, 16'hA5C3)});
    rd(8'h7C, v); chk("R8 cause set on write", {32'b0, v}, 64'h10);
    mon_on = 1'b0;
  endtask

  task automatic t_cause_clear();
    logic [31:0] v;
    wr(8'h7C, 32'hFFFF_FFFF);
    rd(8'h7C, v); chk("R8 write one keeps", {32'b0, v}, 64'h10);
    wr(8'h7C, 32'hFFFF_FFEF);
    rd(8'h7C, v); chk("R8 write zero clears", {32'b0, v}, 64'h0);
  endtask

  task automatic t_read_ok();
    logic [31:0] v;
    start_mon(1'b1, 1'b1, 16'h3C96);
    wr(8'h00, cmd(1'b1, 5'h1F, 5'h02, 16'h0000));
    wait_idle();
    chk("R4 read frame", mon_bits,
        {32'hFFFF_FFFF, 2'b01, 2'b10, 5'h1F, 5'h02, 2'b10, 16'h3C96});
    chk("R4 release pattern", mon_oe, {{46{1'b1}}, {18{1'b0}}});
    rd(8'h00, v);
    chk("R5 valid and data", {32'b0, v}, {32'b0, (32'h1 << 27) | cmd(1'b1, 5'h1F, 5'h02, 16'h3C96)});
    rd(8'h7C, v); chk("R8 cause set on read", {32'b0, v}, 64'h10);
    wr(8'h7C, 32'h0);
    mon_on = 1'b0;
  endtask

  task automatic t_read_noresp();
    logic [31:0] v;
    start_mon(1'b1, 1'b0, 16'h0);
    wr(8'h00, cmd(1'b1, 5'h04, 5'h01, 16'h0000));
    wait_idle();
    rd(8'h00, v);
    chk("R6 no valid without turnaround", {63'b0, v[27]}, 64'd0);
    wr(8'h7C, 32'h0);
    mon_on = 1'b0;
  endtask

  task automatic t_busy_ignore();
    logic [31:0] v;
    start_mon(1'b0, 1'b0, 16'h0);
    wr(8'h00, cmd(1'b0, 5'h03, 5'h07, 16'h1234));
    wr(8'h00, cmd(1'b1, 5'h1C, 5'h18, 16'hFFFF));
    wait_idle();
    chk("R7 frame of first command", mon_bits,
        {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h03, 5'h07, 2'b10, 16'h1234});
    rd(8'h00, v);
    chk("R7 fields of first command", {32'b0, v}, {32'b0, cmd(1'b0, 5'h03, 5'h07, 16'h1234)});
    mon_on = 1'b0;
  endtask

  task automatic t_irq();
    chk("R9 masked irq low", {63'b0, irq}, 64'd0);
    wr(8'h80, 32'h10);
    repeat (2) @(posedge clk); #1;
    chk("R9 irq with mask", {63'b0, irq}, 64'd1);
    wr(8'h7C, 32'h0);
    repeat (2) @(posedge clk); #1;
    chk("R9 irq after clear", {63'b0, irq}, 64'd0);
    wr(8'h80, 32'h0);
  endtask

  task automatic t_collision();
    logic [31:0] v;
    start_mon(1'b0, 1'b0, 16'h0);
    wr(8'h00, cmd(1'b0, 5'h11, 5'h05, 16'h0F0F));
    wait (mon_cnt == FR);
    // last rise at E0; mdc falls at E2; done pulse consumed at E3
    @(posedge clk);
    @(posedge clk); #1;
    reg_addr = 8'h7C; reg_wdata = 32'h0; reg_wen = 1'b1;
    @(posedge clk); #1;
    reg_wen = 1'b0;
    wait_idle();
    rd(8'h7C, v);
    chk("R10 set wins over clear", {32'b0, v}, 64'h10);
    mon_on = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    t_write();
    t_cause_clear();
    t_read_ok();
    t_read_noresp();
    t_busy_ignore();
    t_irq();
    t_collision();
    chk("R11 no change while mdc high", 64'(r11_viol), 64'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule